// File: doc/BRIEF.md
# Seven-Sided Die Pip Display Lookup

This block turns a 3-bit die result into the lamp pattern for a seven-lamp pip display. The lamps sit like die pips: a centre lamp W, and three mirrored pairs around it (T with Z, U with Y, V with X). Because the lamps of each mirrored pair are always on or off together, the lookup table keeps only four stored bits per word: one for each pair and one for the centre. A fan-out stage then spreads those four bits over the seven lamps.

The table is built as a word-line decoder feeding a fixed OR plane. Its content is worked out at elaboration time from the pip rule, not written out by hand. Results 1 to 7 show that many lit lamps. The centre lamp marks odd results, and the pairs join in the order T/Z, V/X, U/Y as the result grows. Result 0 is unused and shows nothing. A registered output stage loads a new pattern only on a clock edge where the valid strobe is high. It holds the pattern otherwise.

Top module: `die_pip_rom`

## Requirements
- R1: While `rst_n` is low, `led_q` is all zeros. The reset is asynchronous and is released on a clock edge.
- R2: On a rising `clk` edge with `value_vld` high, `led_q` takes the pattern for `value`. The pattern is visible right after that edge.
- R3: On a rising `clk` edge with `value_vld` low, `led_q` keeps its value, whatever `value` carries.
- R4: Lamp bit positions are `led_q[0]`=T, `[1]`=U, `[2]`=V, `[3]`=W, `[4]`=X, `[5]`=Y, `[6]`=Z. T equals Z, U equals Y, and V equals X in every loaded pattern.
- R5: The number of lit lamps in a loaded pattern equals the loaded `value`, so value 0 gives all lamps off.
- R6: The centre lamp W (`led_q[3]`) is lit exactly when the loaded `value` is odd.
- R7: Pairs light in a fixed order. T/Z is lit for values 2 and above, V/X for 4 and above, and U/Y for 6 and above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| value_vld | input | 1 | Load strobe for `value` |
| value | input | 3 | Die result, 0 to 7 |
| led_q | output | 7 | Registered lamp pattern, one bit per lamp (see R4) |

## Verification
Every lamp pattern is due exactly one clock edge after the stimulus. The lookup path is purely combinational and ends in the single output register. A strobe-low edge is due at the same edge, and its expected result is the pattern already shown. The driver sets inputs on the falling edge and pushes one expected pattern for each rising edge it spans. The monitor pops and compares on the following falling edge, so each comparison lines up with the register update that produced it.

// File: rtl/die_pip_pkg.sv
package die_pip_pkg;

  localparam int SEL_W  = 3;
  localparam int WORDS  = 1 << SEL_W;
  localparam int COL_N  = 4;
  localparam int LAMP_N = 7;

  // Column meaning inside a stored word
  typedef enum int {
    COL_TZ = 0,
    COL_UY = 1,
    COL_VX = 2,
    COL_W  = 3
  } col_idx_e;

  // Lamp position in the output vector
  typedef enum int {
    LAMP_T = 0,
    LAMP_U = 1,
    LAMP_V = 2,
    LAMP_W = 3,
    LAMP_X = 4,
    LAMP_Y = 5,
    LAMP_Z = 6
  } lamp_idx_e;

  typedef logic [COL_N-1:0]  col_vec_t;
  typedef logic [LAMP_N-1:0] lamp_vec_t;

  // Smallest face value at which a pair turns on
  function automatic int pair_threshold(input int col);
    case (col)
      COL_TZ:  return 2;
      COL_VX:  return 4;
      COL_UY:  return 6;
      default: return WORDS;
    endcase
  endfunction

  // One OR-plane crossing: is column col set in word w
  function automatic logic plane_bit(input int w, input int col);
    if (w == 0)
      return 1'b0;
    if (col == COL_W)
      return logic'(w % 2);
    return logic'(w >= pair_threshold(col));
  endfunction

  // Whole plane, word-major: bit [w*COL_N + c]
  function automatic logic [WORDS*COL_N-1:0] build_plane();
    logic [WORDS*COL_N-1:0] p;
    p = '0;
    for (int w = 0; w < WORDS; w++)
      for (int c = 0; c < COL_N; c++)
        p[w*COL_N + c] = plane_bit(w, c);
    return p;
  endfunction

endpackage

// File: rtl/pip_word_decoder.sv
module pip_word_decoder #(
  parameter int SEL_W = die_pip_pkg::SEL_W,
  localparam int WORDS = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  output logic [WORDS-1:0] word_line
);

  for (genvar w = 0; w < WORDS; w++) begin : g_line
    assign word_line[w] = (sel == SEL_W'(w));
  end

endmodule

// File: rtl/pip_or_plane.sv
module pip_or_plane #(
  parameter int SEL_W = die_pip_pkg::SEL_W,
  parameter int COL_N = die_pip_pkg::COL_N,
  localparam int WORDS = 1 << SEL_W,
  parameter logic [WORDS*COL_N-1:0] PLANE = die_pip_pkg::build_plane()
) (
  input  logic [WORDS-1:0] word_line,
  output logic [COL_N-1:0] bit_line
);

  for (genvar c = 0; c < COL_N; c++) begin : g_col
    logic [WORDS-1:0] taps;
    for (genvar w = 0; w < WORDS; w++) begin : g_tap
      if (PLANE[w*COL_N + c]) begin : g_on
        assign taps[w] = word_line[w];
      end else begin : g_off
        assign taps[w] = 1'b0;
      end
    end
    assign bit_line[c] = |taps;
  end

endmodule

// File: rtl/pip_pair_fanout.sv
module pip_pair_fanout
  import die_pip_pkg::*;
(
  input  col_vec_t  cols,
  output lamp_vec_t lamps
);

  always_comb begin
    lamps         = '0;
    lamps[LAMP_T] = cols[COL_TZ];
    lamps[LAMP_Z] = cols[COL_TZ];
    lamps[LAMP_U] = cols[COL_UY];
    lamps[LAMP_Y] = cols[COL_UY];
    lamps[LAMP_V] = cols[COL_VX];
    lamps[LAMP_X] = cols[COL_VX];
    lamps[LAMP_W] = cols[COL_W];
  end

endmodule

// File: rtl/die_pip_rom.sv
module die_pip_rom
  import die_pip_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             value_vld,
  input  logic [SEL_W-1:0] value,
  output logic [LAMP_N-1:0] led_q
);

  logic [WORDS-1:0] word_line;
  col_vec_t         bit_line;
  lamp_vec_t        lamp_comb;
  lamp_vec_t        lamp_d;
  lamp_vec_t        lamp_r;

  pip_word_decoder #(.SEL_W(SEL_W)) u_dec (
    .sel       (value),
    .word_line (word_line)
  );

  pip_or_plane #(.SEL_W(SEL_W), .COL_N(COL_N)) u_plane (
    .word_line (word_line),
    .bit_line  (bit_line)
  );

  pip_pair_fanout u_fan (
    .cols  (bit_line),
    .lamps (lamp_comb)
  );

  // next state: load on strobe, otherwise hold
  always_comb begin
    lamp_d = lamp_r;
    if (value_vld)
      lamp_d = lamp_comb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lamp_r <= '0;
    else
      lamp_r <= lamp_d;
  end

  assign led_q = lamp_r;

endmodule

// File: rtl/die_pip_chk.sv
module die_pip_chk
  import die_pip_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              value_vld,
  input logic [SEL_W-1:0]  value,
  input logic [LAMP_N-1:0] led_q
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      armed <= 1'b0;
    else
      armed <= 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> led_q == '0);

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(value_vld)) |-> $stable(led_q));

  // R4
  pair_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (led_q[LAMP_T] == led_q[LAMP_Z]) && (led_q[LAMP_U] == led_q[LAMP_Y]) &&
    (led_q[LAMP_V] == led_q[LAMP_X]));

  // R5
  lamp_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(value_vld)) |-> ($countones(led_q) == int'($past(value))));

  // R6
  centre_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(value_vld)) |-> (led_q[LAMP_W] == $past(value[0])));

  // R7
  pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(value_vld)) |->
      ((led_q[LAMP_T] == ($past(value) >= 3'd2)) &&
       (led_q[LAMP_V] == ($past(value) >= 3'd4)) &&
       (led_q[LAMP_U] == ($past(value) >= 3'd6))));

endmodule

bind die_pip_rom die_pip_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .value_vld (value_vld),
  .value     (value),
  .led_q     (led_q)
);

// File: tb/tb_die_pip_rom.sv
`timescale 1ns/1ps
module tb_die_pip_rom;

  logic       clk;
  logic       rst_n;
  logic       value_vld;
  logic [2:0] value;
  logic [6:0] led_q;

  int n_checks = 0;
  int n_fails  = 0;

  logic [6:0] exp_q[$];
  int         val_q[$];   // loaded value, or -1 for a hold edge
  string      tag_q[$];
  logic [6:0] model;      // last pattern the bench expects on led_q

  die_pip_rom dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .value_vld (value_vld),
    .value     (value),
    .led_q     (led_q)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Expected pattern from the requirements (bit order per R4)
  function automatic logic [6:0] pip_pattern(input int v);
    logic [6:0] p;
    p = '0;
    p[3] = (v % 2) == 1;           // R6 centre W
    p[0] = v >= 2; p[6] = v >= 2;  // R7 T/Z
    p[2] = v >= 4; p[4] = v >= 4;  // R7 V/X
    p[1] = v >= 6; p[5] = v >= 6;  // R7 U/Y
    return p;
  endfunction

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: led_q=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver: one rising edge per call
  task automatic drive(input bit vld, input logic [2:0] v, input string tag);
    @(negedge clk);
    value_vld = vld;
    value     = v;
    @(posedge clk);
    if (vld) model = pip_pattern(int'(v));
    exp_q.push_back(model);
    val_q.push_back(vld ? int'(v) : -1);
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [6:0] e;
      int         lv;
      string      t;
      e  = exp_q.pop_front();
      lv = val_q.pop_front();
      t  = tag_q.pop_front();
      check(t, led_q, e);
      if (lv >= 0) begin
        n_checks++;
        if ($countones(led_q) != lv) begin
          n_fails++;
          $display("FAIL R5: lit=%0d expected=%0d", $countones(led_q), lv);
        end
        n_checks++;
        if (led_q[0] !== led_q[6] || led_q[1] !== led_q[5] || led_q[2] !== led_q[4]) begin
          n_fails++;
          $display("FAIL R4: led_q=%b expected mirrored pairs equal", led_q);
        end
      end
    end
  end

  task automatic drain();
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    model     = '0;
    rst_n     = 1'b0;
    value_vld = 1'b0;
    value     = 3'd7;
    repeat (3) @(negedge clk);
    check("R1 reset", led_q, 7'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", led_q, 7'd0);

    // ascending sweep
    for (int v = 0; v < 8; v++) drive(1'b1, 3'(v), "R2 R6 R7 ascending");
    // descending sweep
    for (int v = 7; v >= 0; v--) drive(1'b1, 3'(v), "R2 R7 descending");
    // hold: load 5, then strobe low with changing values
    drive(1'b1, 3'd5, "R2 load 5");
    drive(1'b0, 3'd2, "R3 hold");
    drive(1'b0, 3'd0, "R3 hold");
    drive(1'b0, 3'd7, "R3 hold");
    drive(1'b1, 3'd6, "R2 load 6");
    drive(1'b0, 3'd1, "R3 hold");
    // alternating odd/even back to back
    drive(1'b1, 3'd1, "R6 odd");
    drive(1'b1, 3'd6, "R6 even");
    drive(1'b1, 3'd3, "R6 odd");
    drive(1'b1, 3'd4, "R6 even");
    drive(1'b1, 3'd7, "R5 full");
    drain();

    // asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1 check("R1 async clear", led_q, 7'd0);
    @(negedge clk);
    value_vld = 1'b1;
    value     = 3'd7;
    @(negedge clk);
    check("R1 strobe ignored in reset", led_q, 7'd0);
    value_vld = 1'b0;
    rst_n     = 1'b1;
    model     = '0;
    drive(1'b0, 3'd3, "R3 hold after reset");
    drive(1'b1, 3'd2, "R7 T/Z first pair");
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule